// File: doc/BRIEF.md
# Half-Second Watchdog Timer with Early-Warning Interrupt

This block is a watchdog for a system that runs from a 32.768 kHz low-frequency clock. Software programs a timeout in half-second units and then switches the watchdog on. From that point software must keep proving that it is alive. It does this by writing an ordered pair of key words to a service register. If the count runs out, the block pulses a software-reset request to the system reset logic. It can also pulse an external reset line. It then records that the last reset came from a timeout.

A programmable lead time, also in half-second units, sets a sticky early-warning flag before the count runs out. That flag can raise an interrupt, which gives software a last chance to service the watchdog or to save state. Counting can pause while the system is in a wait, debug or low-power state, and a separate control bit chooses each of these pauses. All registers are 16 bits wide and sit on a simple write-strobe and combinational-read port. A tick parameter sets the number of clock cycles in one half-second unit, so the block can be built with a short unit for fast checking.

Top module: `halfsec_watchdog`

## Requirements
- R1: After reset the registers read as follows: control (offset 0x0) 0x0000, service (0x2) 0x0000, reset cause (0x4) 0x0010 (bit 4, power-on), interrupt control (0x6) 0x0000 and misc (0x8) 0x0000. All outputs are low.
- R2: A control write with bit 2 set starts the count from control bits 15:8 = W. The software-reset request rises (W+1)*TICKS_PER_UNIT cycles after that write edge, and a value of 0 means one unit. It then stays high for exactly PULSE_CYCLES cycles, unless control bit 4 was set, in which case it stays low.
- R3: The external reset pulses together with the software-reset request, for the same cycles, only if control bit 3 is 1 and bit 5 is 0. Otherwise it stays low.
- R4: Writing 0x5555 and then 0xAAAA to offset 0x2 reloads the count. The next expiry comes (W+1)*TICKS_PER_UNIT cycles after the 0xAAAA write.
- R5: A 0xAAAA write that does not follow a 0x5555 write directly reloads nothing, and neither does any other value. Any write other than 0x5555 disarms the sequence.
- R6: The enable bit (control bit 2) cannot be cleared by a write. Only reset clears it, and the count keeps running.
- R7: Interrupt-control bits 7:0 = L, with 0 < L <= W, set the flag in bit 14 (L)*TICKS_PER_UNIT cycles before expiry. No flag is set when L = 0 or L > W. The irq output equals bit 14 AND bit 15.
- R8: Writing 1 to interrupt-control bit 14 clears the flag. Writing 0 to it leaves the flag unchanged.
- R9: With control bit 7, bit 1 or bit 0 set, the count pauses while in_wait, in_debug or in_lowpower is high, respectively. When the matching bit is clear, that input has no effect.
- R10: An expiry sets the reset-cause register to 0x0002 (bit 1). A one-cycle pulse on soft_rst_seen sets it to 0x0001 (bit 0).
- R11: Misc bit 0 is a power-down enable. It reads back and drives pd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| in_wait | input | 1 | System is in wait state |
| in_debug | input | 1 | System is halted for debug |
| in_lowpower | input | 1 | System is in low-power state |
| soft_rst_seen | input | 1 | A software reset of the system took place |
| sw_rst_req | output | 1 | Software-reset request pulse on expiry |
| ext_rst | output | 1 | External reset pulse on expiry |
| irq | output | 1 | Early-warning interrupt |
| pd_en | output | 1 | Power-down enable bit |

## Verification
Two situations are the hardest to reach. The first is the exact cycle where the early-warning flag lands relative to expiry. The second is a pause window that starts and ends in the middle of a half-second unit. Both would need tens of thousands of cycles per unit at the default tick count. The bench builds the block with eight cycles per unit and sweeps every timeout from one to four units against every lead time from zero to four. It computes both event times arithmetically. It also opens a five-cycle pause window at a fixed offset for each mode input, with the matching control bit set and with it clear.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;
    localparam int WT_W   = 8;
    localparam int LEAD_W = 8;
    localparam int UNIT_W = WT_W + 1;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_KICK  = 4'h2;
    localparam logic [ADDR_W-1:0] OFF_CAUSE = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_EARLY = 4'h6;
    localparam logic [ADDR_W-1:0] OFF_MISC  = 4'h8;

    localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

    // control word, field positions fixed by software
    typedef struct packed {
        logic [WT_W-1:0] wt;
        logic            hold_wait;
        logic            rsv6;
        logic            no_ext;
        logic            no_sw;
        logic            ext_sel;
        logic            en;
        logic            hold_dbg;
        logic            hold_lp;
    } ctrl_t;

    typedef struct packed {
        logic              ie;
        logic              flag;
        logic [5:0]        rsv;
        logic [LEAD_W-1:0] lead;
    } early_t;

    typedef enum logic [1:0] {
        CAUSE_POR  = 2'd0,
        CAUSE_TOUT = 2'd1,
        CAUSE_SOFT = 2'd2
    } cause_e;

    function automatic logic [REG_W-1:0] cause_word(cause_e c);
        case (c)
            CAUSE_POR:  return 16'h0010;
            CAUSE_TOUT: return 16'h0002;
            CAUSE_SOFT: return 16'h0001;
            default:    return 16'h0000;
        endcase
    endfunction

    function automatic logic [UNIT_W-1:0] units_of(logic [WT_W-1:0] wt);
        return {1'b0, wt} + UNIT_W'(1);
    endfunction

    function automatic logic may_count(ctrl_t c, logic w, logic d, logic l);
        return c.en & ~(c.hold_wait & w) & ~(c.hold_dbg & d) & ~(c.hold_lp & l);
    endfunction

endpackage

// File: rtl/hsw_regs.sv
module hsw_regs
    import hsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              soft_evt,
    input  logic              expire,
    input  logic              lead_hit,
    output ctrl_t             ctrl,
    output early_t            early,
    output logic              pd_en,
    output logic              reload,
    output logic [UNIT_W-1:0] load_units
);

    ctrl_t  ctrl_q;
    early_t early_q;
    cause_e cause_q;
    logic   misc_q;
    logic   armed_q;

    logic   wr_ctrl, wr_kick, wr_early, wr_misc;
    logic   en_start, kick_ok;
    ctrl_t  ctrl_in;

    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
        wr_kick  = bus_wr && (bus_addr == OFF_KICK);
        wr_early = bus_wr && (bus_addr == OFF_EARLY);
        wr_misc  = bus_wr && (bus_addr == OFF_MISC);
        ctrl_in      = ctrl_t'(bus_wdata);
        ctrl_in.rsv6 = 1'b0;
        ctrl_in.en   = ctrl_q.en | ctrl_in.en;
        en_start = wr_ctrl && bus_wdata[2] && !ctrl_q.en;
        kick_ok  = wr_kick && (bus_wdata == KEY_FIRE) && armed_q;
        reload   = en_start || kick_ok;
        load_units = en_start ? units_of(bus_wdata[15:8]) : units_of(ctrl_q.wt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (wr_kick) begin
            armed_q <= (bus_wdata == KEY_ARM);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            early_q <= '0;
        end else begin
            if (wr_early) begin
                early_q.ie   <= bus_wdata[15];
                early_q.lead <= bus_wdata[LEAD_W-1:0];
            end
            if (lead_hit) begin
                early_q.flag <= 1'b1;
            end else if (wr_early && bus_wdata[14]) begin
                early_q.flag <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= CAUSE_POR;
        end else if (soft_evt) begin
            cause_q <= CAUSE_SOFT;
        end else if (expire) begin
            cause_q <= CAUSE_TOUT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            misc_q <= 1'b0;
        end else if (wr_misc) begin
            misc_q <= bus_wdata[0];
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_CTRL:  bus_rdata = ctrl_q;
            OFF_CAUSE: bus_rdata = cause_word(cause_q);
            OFF_EARLY: bus_rdata = early_q;
            OFF_MISC:  bus_rdata = {{(REG_W-1){1'b0}}, misc_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign ctrl  = ctrl_q;
    assign early = early_q;
    assign pd_en = misc_q;

    // R6
    en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_q.en) |-> ctrl_q.en);

    // R5
    kick_order_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_kick && !armed_q) |-> !reload);

    // R7
    flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(early_q.flag) |-> $past(lead_hit));

    // R10
    cause_tout_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && !soft_evt) |=> (bus_addr != OFF_CAUSE || bus_rdata == 16'h0002));

endmodule

// File: rtl/hsw_counter.sv
module hsw_counter
    import hsw_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 16384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              reload,
    input  logic [UNIT_W-1:0] load_units,
    input  logic [LEAD_W-1:0] lead,
    output logic              expire,
    output logic              lead_hit
);

    localparam int TICK_W = (TICKS_PER_UNIT > 2) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [TICK_W-1:0] LAST = TICK_W'(TICKS_PER_UNIT - 1);

    logic [TICK_W-1:0] tick_q;
    logic [UNIT_W-1:0] units_q;
    logic              unit_end;

    always_comb begin
        unit_end = run && !reload && (tick_q == LAST);
        expire   = unit_end && (units_q == UNIT_W'(1));
        lead_hit = unit_end && (lead != '0) &&
                   (units_q == ({1'b0, lead} + UNIT_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= '0;
            units_q <= '0;
        end else if (reload || expire) begin
            tick_q  <= '0;
            units_q <= load_units;
        end else if (run) begin
            if (tick_q == LAST) begin
                tick_q  <= '0;
                units_q <= units_q - UNIT_W'(1);
            end else begin
                tick_q <= tick_q + TICK_W'(1);
            end
        end
    end

    // R9
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !reload) |=> ($stable(units_q) && $stable(tick_q)));

    // R2
    units_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !reload && tick_q != LAST) |=> $stable(units_q));

endmodule

// File: rtl/hsw_pulse.sv
module hsw_pulse #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic allow,
    output logic active
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (fire && allow) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign active = (cnt_q != '0);

    // R3
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(fire && allow));

endmodule

// File: rtl/halfsec_watchdog.sv
module halfsec_watchdog
    import hsw_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 16384,
    parameter int PULSE_CYCLES   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        in_wait,
    input  logic        in_debug,
    input  logic        in_lowpower,
    input  logic        soft_rst_seen,
    output logic        sw_rst_req,
    output logic        ext_rst,
    output logic        irq,
    output logic        pd_en
);

    ctrl_t             ctrl;
    early_t            early;
    logic              reload, expire, lead_hit, run;
    logic [UNIT_W-1:0] load_units;
    logic [1:0]        allow_v, act_v;

    hsw_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .soft_evt   (soft_rst_seen),
        .expire     (expire),
        .lead_hit   (lead_hit),
        .ctrl       (ctrl),
        .early      (early),
        .pd_en      (pd_en),
        .reload     (reload),
        .load_units (load_units)
    );

    assign run = may_count(ctrl, in_wait, in_debug, in_lowpower);

    hsw_counter #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .reload     (reload),
        .load_units (load_units),
        .lead       (early.lead),
        .expire     (expire),
        .lead_hit   (lead_hit)
    );

    assign allow_v[0] = !ctrl.no_sw;
    assign allow_v[1] = ctrl.ext_sel && !ctrl.no_ext;

    for (genvar g = 0; g < 2; g++) begin : g_pulse
        hsw_pulse #(.CYCLES(PULSE_CYCLES)) u_pulse (
            .clk    (clk),
            .rst    (rst),
            .fire   (expire),
            .allow  (allow_v[g]),
            .active (act_v[g])
        );
    end

    assign sw_rst_req = act_v[0];
    assign ext_rst    = act_v[1];
    assign irq        = early.ie && early.flag;

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (early.ie && ($past(lead_hit) || $rose(early.ie))));

endmodule

// File: tb/halfsec_watchdog_bench.sv
module halfsec_watchdog_bench;

    localparam int T = 8;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        in_wait = 1'b0, in_debug = 1'b0, in_lowpower = 1'b0;
    logic        soft_rst_seen = 1'b0;
    logic        sw_rst_req, ext_rst, irq, pd_en;

    int cyc = 0;
    int t0 = 0;
    int n_chk = 0;
    int n_fail = 0;

    halfsec_watchdog #(.TICKS_PER_UNIT(T), .PULSE_CYCLES(P)) u_halfsec_watchdog (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_wait(in_wait),
        .in_debug(in_debug), .in_lowpower(in_lowpower),
        .soft_rst_seen(soft_rst_seen), .sw_rst_req(sw_rst_req),
        .ext_rst(ext_rst), .irq(irq), .pd_en(pd_en)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_wait = 1'b0; in_debug = 1'b0; in_lowpower = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_sw(output int dt);
        int k = 0;
        while (!sw_rst_req && k < 2000) begin
            @(negedge clk);
            k++;
        end
        dt = sw_rst_req ? (cyc - t0) : -1;
    endtask

    task automatic pulse_len(output int w);
        w = 0;
        while (sw_rst_req && w < 100) begin
            @(negedge clk);
            w++;
        end
    endtask

    initial begin
        int v, dt, irq_t, w, k;
        do_reset();

        // R1 reset state
        rd_reg(4'h0, v); check("R1 ctrl", v, 0);
        rd_reg(4'h2, v); check("R1 kick", v, 0);
        rd_reg(4'h4, v); check("R1 cause", v, 16'h0010);
        rd_reg(4'h6, v); check("R1 early", v, 0);
        rd_reg(4'h8, v); check("R1 misc", v, 0);
        check("R1 outputs", {sw_rst_req, ext_rst, irq, pd_en}, 0);

        // R2 R3 R7 sweep of timeout and lead
        for (int wt = 0; wt < 4; wt++) begin
            for (int ld = 0; ld < 5; ld++) begin
                do_reset();
                wr_reg(4'h6, 16'h8000 | 16'(ld));
                wr_reg(4'h0, {8'(wt), 8'h0C});
                t0 = cyc; irq_t = -1; k = 0;
                while (!sw_rst_req && k < 200) begin
                    if (irq && irq_t < 0) irq_t = cyc - t0;
                    @(negedge clk);
                    k++;
                end
                dt = sw_rst_req ? (cyc - t0) : -1;
                check("R2 expiry time", dt, (wt + 1) * T);
                check("R3 ext with sw", int'(ext_rst), 1);
                check("R7 irq time", irq_t, (ld > 0 && ld <= wt) ? (wt + 1 - ld) * T : -1);
                rd_reg(4'h6, v);
                check("R7 flag bit14", (v >> 14) & 1, (ld > 0 && ld <= wt) ? 1 : 0);
                pulse_len(w);
                check("R2 pulse width", w, P);
                rd_reg(4'h4, v);
                check("R10 cause tout", v, 16'h0002);
            end
        end

        // R2 R3 suppression: bit4 and bit5 set, bit3 set
        do_reset();
        wr_reg(4'h0, 16'h003C);
        repeat (T + 1) @(negedge clk);
        check("R2 sw suppressed", int'(sw_rst_req), 0);
        check("R3 ext suppressed", int'(ext_rst), 0);
        rd_reg(4'h4, v);
        check("R10 cause tout suppressed", v, 16'h0002);

        // R3 ext not selected
        do_reset();
        wr_reg(4'h0, 16'h0004);
        t0 = cyc;
        wait_sw(dt);
        check("R2 plain expiry", dt, T);
        w = 0;
        for (int i = 0; i < P; i++) begin
            if (ext_rst) w++;
            @(negedge clk);
        end
        check("R3 ext unselected", w, 0);

        // R4 valid service
        do_reset();
        wr_reg(4'h0, 16'h0304);
        repeat (10) @(negedge clk);
        wr_reg(4'h2, 16'h5555);
        wr_reg(4'h2, 16'hAAAA);
        t0 = cyc;
        wait_sw(dt);
        check("R4 reload", dt, 4 * T);

        // R5 broken sequence
        do_reset();
        wr_reg(4'h0, 16'h0304);
        t0 = cyc;
        wr_reg(4'h2, 16'h5555);
        wr_reg(4'h2, 16'h1234);
        wr_reg(4'h2, 16'hAAAA);
        wr_reg(4'h2, 16'hAAAA);
        wait_sw(dt);
        check("R5 no reload", dt, 4 * T);

        // R6 write-once enable
        do_reset();
        wr_reg(4'h0, 16'h0204);
        t0 = cyc;
        wr_reg(4'h0, 16'h0200);
        rd_reg(4'h0, v);
        check("R6 enable kept", v, 16'h0204);
        wait_sw(dt);
        check("R6 still counts", dt, 3 * T);

        // R9 pause modes, bit set then clear
        for (int m = 0; m < 3; m++) begin
            for (int on = 0; on < 2; on++) begin
                do_reset();
                wr_reg(4'h0, 16'h0104 | ((on == 1) ? ((m == 0) ? 16'h80 : (m == 1) ? 16'h02 : 16'h01) : 16'h0));
                t0 = cyc;
                repeat (3) @(negedge clk);
                if (m == 0) in_wait = 1'b1; else if (m == 1) in_debug = 1'b1; else in_lowpower = 1'b1;
                repeat (5) @(negedge clk);
                in_wait = 1'b0; in_debug = 1'b0; in_lowpower = 1'b0;
                wait_sw(dt);
                check($sformatf("R9 pause mode%0d bit%0d", m, on), dt, 2 * T + ((on == 1) ? 5 : 0));
            end
        end

        // R8 write-one-to-clear
        do_reset();
        wr_reg(4'h6, 16'h8001);
        wr_reg(4'h0, 16'h0104);
        repeat (T + 2) @(negedge clk);
        check("R7 irq raised", int'(irq), 1);
        wr_reg(4'h6, 16'h8001);
        rd_reg(4'h6, v);
        check("R8 write0 keeps", v, 16'hC001);
        wr_reg(4'h6, 16'hC001);
        rd_reg(4'h6, v);
        check("R8 write1 clears", v, 16'h8001);
        check("R8 irq low", int'(irq), 0);

        // R7 interrupt disabled: flag only
        do_reset();
        wr_reg(4'h6, 16'h0001);
        wr_reg(4'h0, 16'h0104);
        t0 = cyc; w = 0; k = 0;
        while (!sw_rst_req && k < 200) begin
            if (irq) w++;
            @(negedge clk);
            k++;
        end
        check("R7 irq masked", w, 0);
        rd_reg(4'h6, v);
        check("R7 flag masked", v, 16'h4001);

        // R10 soft reset cause
        soft_rst_seen = 1'b1;
        @(negedge clk);
        soft_rst_seen = 1'b0;
        rd_reg(4'h4, v);
        check("R10 cause soft", v, 16'h0001);

        // R11 misc
        wr_reg(4'h8, 16'hFFFF);
        rd_reg(4'h8, v);
        check("R11 misc read", v, 1);
        check("R11 pd_en on", int'(pd_en), 1);
        wr_reg(4'h8, 16'h0000);
        check("R11 pd_en off", int'(pd_en), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule